// File: doc/BRIEF.md
# DDR SDRAM Command Decoder and Bank Monitor

This block watches the control pins of a DDR SDRAM command bus and samples them on every rising clock. It turns each cycle's pin pattern into one command code. It keeps a per-bank record of which banks hold an open row and which row each one holds. It also follows the read or write burst in flight, including bursts that close their bank automatically when they end. Any command that the current bank or burst state does not allow raises a one-cycle violation flag.

Every output is registered. The values seen after clock edge k describe the command sampled at edge k and the tracking state as it stands after that edge. A violating command is reported and flagged, but it does not change the tracked state. The block is meant to sit beside a memory controller or a bus model as a protocol monitor. It does no timing-parameter checks and does not handle the data path.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: When the chip select input is high, every other pin is ignored and the cycle reports the no-operation code 0, with no flag and no state change.
- R2: With chip select low, the row, column and write strobes (active low, in that order) decode as follows. HHH gives no-op (0), LHH activate (1), HLH read (2), HLL write (3), HHL burst stop (4), LHL precharge (5), LLH refresh (6) and LLL mode-register load (8). The refresh pattern with clock enable low gives self-refresh entry (7).
- R3: On a read or write, `ap_o` equals address bit 10. `bank_o` and `addr_o` carry the sampled bank and column.
- R4: A legal precharge with address bit 10 high closes every bank, ignores the bank inputs and sets `pre_all_o`. With bit 10 low it closes only the addressed bank.
- R5: A legal activate marks its bank open and stores the row, which `row_o` reports. An activate to a bank that is already open is flagged.
- R6: A read or write is flagged when its bank is closed or while a burst with auto precharge is still running.
- R7: A legal read or write keeps `burst_o` high for BL/2 edges. A burst with auto precharge clears its bank's open flag at the last of those edges.
- R8: Burst stop is legal only during a read burst without auto precharge, and it ends that burst. During a write burst, an auto-precharge burst or no burst, it is flagged.
- R9: Refresh, self-refresh entry and mode-register load are flagged unless all banks are closed.
- R10: On a mode-register load, bank code 00 gives `mr_ext_o` = 0 and bank code 01 gives `mr_ext_o` = 1, with `addr_o` carrying the op-code. A set bank bit 1 is reserved and flagged.
- R11: After a legal self-refresh entry, `self_ref_o` is high. Every input except clock enable is then ignored (reported as code 0), and the block leaves self refresh at the first edge where clock enable is high.
- R12: During a write burst, each cycle's data mask low sets `beat_wr_o` and data mask high sets `beat_mask_o`. Outside a write burst, both are low.
- R13: A flagged command leaves the open flags, stored rows and burst state unchanged.
- R14: While reset is asserted, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 13 | Row, column or op-code address |
| dm | input | 1 | Data mask pin |
| cmd_o | output | 4 | Decoded command code |
| bank_o | output | 2 | Bank of the command |
| addr_o | output | 13 | Address of the command |
| row_o | output | 13 | Row held by the addressed bank after the edge |
| ap_o | output | 1 | Read/write requested auto precharge |
| pre_all_o | output | 1 | Precharge targeted all banks |
| mr_ext_o | output | 1 | Mode-register load targeted the extended register |
| illegal_o | output | 1 | Command violated the protocol state |
| bank_open_o | output | 4 | Per-bank open-row flags |
| burst_o | output | 1 | Read or write burst in progress |
| self_ref_o | output | 1 | Device is in self refresh |
| beat_wr_o | output | 1 | Write beat accepted this cycle |
| beat_mask_o | output | 1 | Write beat masked this cycle |

## Verification
A wrong open flag appears at `bank_open_o` on the very next edge. It also shows one edge later as a wrongly set or missing `illegal_o` on the next activate, read or write to that bank. A burst counter that is off by one moves the edge where an auto-precharge bank closes and where `burst_o` falls, so the bench samples these at the exact edge. A stuck self-refresh state shows as activates that report code 0 and never open a bank.

// File: rtl/ddr_mon_pkg.sv
package ddr_mon_pkg;

  typedef enum logic [3:0] {
    CMD_NOP = 4'd0,
    CMD_ACT = 4'd1,
    CMD_RD  = 4'd2,
    CMD_WR  = 4'd3,
    CMD_BST = 4'd4,
    CMD_PRE = 4'd5,
    CMD_REF = 4'd6,
    CMD_SRE = 4'd7,
    CMD_LMR = 4'd8
  } cmd_t;

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_mon_pkg::*;
(
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_t cmd
);

  always_comb begin
    cmd = CMD_NOP;
    if (!cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b111: cmd = CMD_NOP;
        3'b011: cmd = CMD_ACT;
        3'b101: cmd = CMD_RD;
        3'b100: cmd = CMD_WR;
        3'b110: cmd = CMD_BST;
        3'b010: cmd = CMD_PRE;
        3'b001: cmd = cke ? CMD_REF : CMD_SRE;
        3'b000: cmd = CMD_LMR;
        default: cmd = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker #(
  parameter int BANKS  = 4,
  parameter int ADDR_W = 13,
  localparam int BA_W  = $clog2(BANKS)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           open_en,
  input  logic [BA_W-1:0]                open_bank,
  input  logic [ADDR_W-1:0]              open_row,
  input  logic [BANKS-1:0]               close_mask,
  output logic [BANKS-1:0]               open_vec,
  output logic [BANKS-1:0][ADDR_W-1:0]   rows
);

  logic [BANKS-1:0] open_d;

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    logic hit;
    assign hit = open_en && (open_bank == BA_W'(g));

    always_comb begin
      open_d[g] = open_vec[g];
      if (close_mask[g]) open_d[g] = 1'b0;
      if (hit)           open_d[g] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_vec[g] <= 1'b0;
        rows[g]     <= '0;
      end else begin
        open_vec[g] <= open_d[g];
        if (hit) rows[g] <= open_row;
      end
    end
  end

  // R4: a full close mask with no activate leaves every bank closed
  a_r4_close_all: assert property (@(posedge clk) disable iff (!rst_n)
    (&close_mask && !open_en) |=> (open_vec == '0));

endmodule

// File: rtl/ddr_burst_tracker.sv
module ddr_burst_tracker #(
  parameter int BANKS = 4,
  parameter int BL    = 4,
  localparam int BA_W  = $clog2(BANKS),
  localparam int CYC   = BL / 2,
  localparam int CNT_W = $clog2(CYC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            start_wr,
  input  logic            start_ap,
  input  logic [BA_W-1:0] start_bank,
  input  logic            stop,
  output logic            active,
  output logic            is_wr,
  output logic            is_ap,
  output logic [BA_W-1:0] bank,
  output logic            ap_done
);

  logic [CNT_W-1:0] left_q, left_d;
  logic             wr_d, ap_d;
  logic [BA_W-1:0]  bank_d;

  assign active  = (left_q != '0);
  assign ap_done = active && is_ap && (left_q == CNT_W'(1));

  always_comb begin
    left_d = active ? left_q - CNT_W'(1) : '0;
    wr_d   = is_wr;
    ap_d   = is_ap;
    bank_d = bank;
    if (stop) left_d = '0;
    if (start) begin
      left_d = CNT_W'(CYC);
      wr_d   = start_wr;
      ap_d   = start_ap;
      bank_d = start_bank;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      is_wr  <= 1'b0;
      is_ap  <= 1'b0;
      bank   <= '0;
    end else begin
      left_q <= left_d;
      if (start) begin
        is_wr <= wr_d;
        is_ap <= ap_d;
        bank  <= bank_d;
      end
    end
  end

  // R6: a burst with auto precharge is never restarted
  a_r6_no_restart_ap: assert property (@(posedge clk) disable iff (!rst_n)
    (active && is_ap) |-> !start);

  // R8: a stop is only accepted during a plain read burst
  a_r8_stop_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    stop |-> (active && !is_wr && !is_ap));

endmodule

// File: rtl/ddr_cmd_monitor.sv
module ddr_cmd_monitor
  import ddr_mon_pkg::*;
#(
  parameter int BANKS  = 4,
  parameter int ADDR_W = 13,
  parameter int BL     = 4,
  parameter int AP_BIT = 10,
  localparam int BA_W  = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dm,
  output logic [3:0]        cmd_o,
  output logic [BA_W-1:0]   bank_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] row_o,
  output logic              ap_o,
  output logic              pre_all_o,
  output logic              mr_ext_o,
  output logic              illegal_o,
  output logic [BANKS-1:0]  bank_open_o,
  output logic              burst_o,
  output logic              self_ref_o,
  output logic              beat_wr_o,
  output logic              beat_mask_o
);

  cmd_t                         dec, cmd_eff;
  logic                         sr_q, sr_d;
  logic [BANKS-1:0]             open_vec, close_mask;
  logic [BANKS-1:0][ADDR_W-1:0] rows;
  logic                         b_active, b_wr, b_ap, b_done;
  logic [BA_W-1:0]              b_bank;
  logic                         a10, bank_hit, all_closed, bad;
  logic                         act_ok, rw_ok, pre_ok, bst_ok, sre_ok;

  ddr_cmd_decode u_dec (
    .cke   (cke),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd   (dec)
  );

  assign cmd_eff    = sr_q ? CMD_NOP : dec;
  assign a10        = addr[AP_BIT];
  assign bank_hit   = open_vec[ba];
  assign all_closed = (open_vec == '0);

  always_comb begin
    bad = 1'b0;
    unique case (cmd_eff)
      CMD_ACT:         bad = bank_hit;
      CMD_RD, CMD_WR:  bad = !bank_hit || (b_active && b_ap);
      CMD_BST:         bad = !(b_active && !b_wr && !b_ap);
      CMD_REF, CMD_SRE: bad = !all_closed;
      CMD_LMR:         bad = !all_closed || (ba[BA_W-1:1] != '0);
      default:         bad = 1'b0;
    endcase
  end

  assign act_ok = (cmd_eff == CMD_ACT) && !bad;
  assign rw_ok  = ((cmd_eff == CMD_RD) || (cmd_eff == CMD_WR)) && !bad;
  assign pre_ok = (cmd_eff == CMD_PRE);
  assign bst_ok = (cmd_eff == CMD_BST) && !bad;
  assign sre_ok = (cmd_eff == CMD_SRE) && !bad;

  always_comb begin
    close_mask = '0;
    if (pre_ok) close_mask = a10 ? '1 : (BANKS'(1) << ba);
    if (b_done) close_mask = close_mask | (BANKS'(1) << b_bank);
  end

  ddr_bank_tracker #(.BANKS(BANKS), .ADDR_W(ADDR_W)) u_banks (
    .clk        (clk),
    .rst_n      (rst_n),
    .open_en    (act_ok),
    .open_bank  (ba),
    .open_row   (addr),
    .close_mask (close_mask),
    .open_vec   (open_vec),
    .rows       (rows)
  );

  ddr_burst_tracker #(.BANKS(BANKS), .BL(BL)) u_burst (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (rw_ok),
    .start_wr   (cmd_eff == CMD_WR),
    .start_ap   (a10),
    .start_bank (ba),
    .stop       (bst_ok),
    .active     (b_active),
    .is_wr      (b_wr),
    .is_ap      (b_ap),
    .bank       (b_bank),
    .ap_done    (b_done)
  );

  assign sr_d = sr_q ? !cke : sre_ok;

  logic [3:0]        cmd_d;
  logic [BA_W-1:0]   bank_d;
  logic [ADDR_W-1:0] addr_d, row_d;
  logic              ap_d, pall_d, mext_d, ill_d, bwr_d, bmask_d;

  always_comb begin
    cmd_d   = cmd_eff;
    bank_d  = sr_q ? '0 : ba;
    addr_d  = sr_q ? '0 : addr;
    row_d   = act_ok ? addr : rows[ba];
    if (sr_q) row_d = '0;
    ap_d    = ((cmd_eff == CMD_RD) || (cmd_eff == CMD_WR)) && a10;
    pall_d  = (cmd_eff == CMD_PRE) && a10;
    mext_d  = (cmd_eff == CMD_LMR) && ba[0];
    ill_d   = bad;
    bwr_d   = !sr_q && b_active && b_wr && !dm;
    bmask_d = !sr_q && b_active && b_wr && dm;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q        <= 1'b0;
      cmd_o       <= '0;
      bank_o      <= '0;
      addr_o      <= '0;
      row_o       <= '0;
      ap_o        <= 1'b0;
      pre_all_o   <= 1'b0;
      mr_ext_o    <= 1'b0;
      illegal_o   <= 1'b0;
      beat_wr_o   <= 1'b0;
      beat_mask_o <= 1'b0;
    end else begin
      sr_q        <= sr_d;
      cmd_o       <= cmd_d;
      bank_o      <= bank_d;
      addr_o      <= addr_d;
      row_o       <= row_d;
      ap_o        <= ap_d;
      pre_all_o   <= pall_d;
      mr_ext_o    <= mext_d;
      illegal_o   <= ill_d;
      beat_wr_o   <= bwr_d;
      beat_mask_o <= bmask_d;
    end
  end

  assign bank_open_o = open_vec;
  assign burst_o     = b_active;
  assign self_ref_o  = sr_q;

  // R5: an activate to a closed bank leaves that bank open
  a_r5_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (!sr_q && dec == CMD_ACT && !open_vec[ba]) |=> open_vec[$past(ba)]);

  // R6: a read or write to a closed bank raises the flag
  a_r6_rw_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (!sr_q && (dec == CMD_RD || dec == CMD_WR) && !open_vec[ba]) |=> illegal_o);

  // R11: in self refresh with clock enable low nothing is tracked
  a_r11_sr_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_q && !cke) |=> ($stable(open_vec) && self_ref_o && !illegal_o));

endmodule

// File: tb/ddr_cmd_monitor_test.sv
module ddr_cmd_monitor_test;

  localparam logic [3:0] P_NOP = 4'b0111, P_ACT = 4'b0011, P_RD  = 4'b0101,
                         P_WR  = 4'b0100, P_BST = 4'b0110, P_PRE = 4'b0010,
                         P_REF = 4'b0001, P_LMR = 4'b0000, P_DES = 4'b1000;
  localparam logic [3:0] C_NOP = 4'd0, C_ACT = 4'd1, C_RD = 4'd2, C_WR = 4'd3,
                         C_BST = 4'd4, C_PRE = 4'd5, C_REF = 4'd6, C_SRE = 4'd7,
                         C_LMR = 4'd8;

  logic        clk, rst_n, cke, cs_n, ras_n, cas_n, we_n, dm;
  logic [1:0]  ba;
  logic [12:0] addr;
  logic [3:0]  cmd_o, bank_open_o;
  logic [1:0]  bank_o;
  logic [12:0] addr_o, row_o;
  logic        ap_o, pre_all_o, mr_ext_o, illegal_o, burst_o, self_ref_o;
  logic        beat_wr_o, beat_mask_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  ddr_cmd_monitor uut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .dm(dm),
    .cmd_o(cmd_o), .bank_o(bank_o), .addr_o(addr_o), .row_o(row_o),
    .ap_o(ap_o), .pre_all_o(pre_all_o), .mr_ext_o(mr_ext_o),
    .illegal_o(illegal_o), .bank_open_o(bank_open_o), .burst_o(burst_o),
    .self_ref_o(self_ref_o), .beat_wr_o(beat_wr_o), .beat_mask_o(beat_mask_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [29:0] mk(input logic k, input logic [3:0] p,
      input logic [1:0] b, input logic [12:0] a, input logic m,
      input logic [3:0] c, input logic il, input logic [3:0] op);
    return {k, p, b, a, m, c, il, op};
  endfunction

  // fields: cke, pins{cs,ras,cas,we}, ba, addr, dm | expected cmd, flag, open banks
  localparam int NV = 21;
  localparam logic [29:0] VEC [NV] = '{
    mk(1, P_DES, 2'd3, 13'h1FFF, 0, C_NOP, 0, 4'b0000), // R1
    mk(1, P_ACT, 2'd1, 13'h0123, 0, C_ACT, 0, 4'b0010), // R2 R5
    mk(1, P_ACT, 2'd1, 13'h0050, 0, C_ACT, 1, 4'b0010), // R5 reopen
    mk(1, P_RD,  2'd2, 13'h0000, 0, C_RD,  1, 4'b0010), // R6 closed bank
    mk(1, P_RD,  2'd1, 13'h0004, 0, C_RD,  0, 4'b0010), // R2
    mk(1, P_BST, 2'd0, 13'h0000, 0, C_BST, 0, 4'b0010), // R8 legal
    mk(1, P_BST, 2'd0, 13'h0000, 0, C_BST, 1, 4'b0010), // R8 no burst
    mk(1, P_ACT, 2'd3, 13'h0777, 0, C_ACT, 0, 4'b1010),
    mk(1, P_REF, 2'd0, 13'h0000, 0, C_REF, 1, 4'b1010), // R9
    mk(1, P_LMR, 2'd0, 13'h0000, 0, C_LMR, 1, 4'b1010), // R9
    mk(1, P_WR,  2'd3, 13'h0400, 0, C_WR,  0, 4'b1010), // R2 R7
    mk(1, P_BST, 2'd0, 13'h0000, 0, C_BST, 1, 4'b1010), // R8 write
    mk(1, P_NOP, 2'd0, 13'h0000, 0, C_NOP, 0, 4'b0010), // R7 ap close
    mk(1, P_PRE, 2'd1, 13'h0000, 0, C_PRE, 0, 4'b0000), // R4 single
    mk(1, P_ACT, 2'd0, 13'h0001, 0, C_ACT, 0, 4'b0001),
    mk(1, P_ACT, 2'd2, 13'h0002, 0, C_ACT, 0, 4'b0101),
    mk(1, P_PRE, 2'd1, 13'h0400, 0, C_PRE, 0, 4'b0000), // R4 all
    mk(1, P_LMR, 2'd2, 13'h0000, 0, C_LMR, 1, 4'b0000), // R10 reserved
    mk(1, P_LMR, 2'd1, 13'h0055, 0, C_LMR, 0, 4'b0000), // R10
    mk(1, P_REF, 2'd0, 13'h0000, 0, C_REF, 0, 4'b0000), // R2 R9
    mk(1, P_RD,  2'd0, 13'h0000, 0, C_RD,  1, 4'b0000)  // R6
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic k, input logic [3:0] p, input logic [1:0] b,
                       input logic [12:0] a, input logic m);
    @(negedge clk);
    cke = k; {cs_n, ras_n, cas_n, we_n} = p; ba = b; addr = a; dm = m;
    @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cke = 1'b1; {cs_n, ras_n, cas_n, we_n} = P_DES;
    ba = '0; addr = '0; dm = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    // R14 reset state
    check("R14 cmd", cmd_o, 0);
    check("R14 banks", bank_open_o, 0);
    check("R14 flags", {illegal_o, burst_o, self_ref_o, beat_wr_o, beat_mask_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][29], VEC[i][28:25], VEC[i][24:23], VEC[i][22:10], VEC[i][9]);
      check($sformatf("R2 vec%0d cmd", i), cmd_o, VEC[i][8:5]);
      check($sformatf("R13 vec%0d flag", i), illegal_o, VEC[i][4]);
      check($sformatf("R5 vec%0d banks", i), bank_open_o, VEC[i][3:0]);
    end

    // R3 R6 R7 R13: rows, auto-precharge read, burst timing
    drive(1, P_ACT, 2'd2, 13'h0111, 0);
    check("R5 row", row_o, 13'h0111);
    drive(1, P_ACT, 2'd2, 13'h0222, 0);
    check("R13 flag", illegal_o, 1);
    check("R13 row kept", row_o, 13'h0111);
    drive(1, P_RD, 2'd2, 13'h0408, 0);
    check("R3 ap", ap_o, 1);
    check("R3 addr", addr_o, 13'h0408);
    check("R3 bank", bank_o, 2);
    check("R13 row after read", row_o, 13'h0111);
    check("R7 burst on", burst_o, 1);
    drive(1, P_RD, 2'd2, 13'h0000, 0);
    check("R6 rw during ap", illegal_o, 1);
    check("R7 still open", bank_open_o, 4'b0100);
    check("R7 burst mid", burst_o, 1);
    drive(1, P_NOP, 2'd0, 13'h0000, 0);
    check("R7 ap closed", bank_open_o, 4'b0000);
    check("R7 burst off", burst_o, 0);

    // R12 write mask
    drive(1, P_ACT, 2'd1, 13'h0033, 0);
    drive(1, P_WR, 2'd1, 13'h0010, 0);
    check("R3 no ap", ap_o, 0);
    drive(1, P_NOP, 2'd0, 13'h0000, 0);
    check("R12 beat wr", {beat_wr_o, beat_mask_o}, 2'b10);
    drive(1, P_NOP, 2'd0, 13'h0000, 1);
    check("R12 beat mask", {beat_wr_o, beat_mask_o}, 2'b01);
    drive(1, P_NOP, 2'd0, 13'h0000, 1);
    check("R12 after burst", {beat_wr_o, beat_mask_o}, 2'b00);

    // R4 precharge variants
    drive(1, P_ACT, 2'd3, 13'h0044, 0);
    drive(1, P_PRE, 2'd1, 13'h0000, 0);
    check("R4 single", bank_open_o, 4'b1000);
    check("R4 pre_all low", pre_all_o, 0);
    drive(1, P_PRE, 2'd0, 13'h0400, 0);
    check("R4 all", bank_open_o, 4'b0000);
    check("R4 pre_all high", pre_all_o, 1);

    // R10 register selection
    drive(1, P_LMR, 2'd1, 13'h0002, 0);
    check("R10 ext", mr_ext_o, 1);
    drive(1, P_LMR, 2'd0, 13'h01AA, 0);
    check("R10 base", {illegal_o, mr_ext_o}, 2'b00);
    check("R10 opcode", addr_o, 13'h01AA);

    // R11 self refresh
    drive(0, P_REF, 2'd0, 13'h0000, 0);
    check("R11 entry cmd", cmd_o, C_SRE);
    check("R11 entry", self_ref_o, 1);
    drive(0, P_ACT, 2'd0, 13'h0099, 0);
    check("R11 ignored cmd", cmd_o, C_NOP);
    check("R11 ignored banks", bank_open_o, 4'b0000);
    check("R11 ignored flag", illegal_o, 0);
    drive(1, P_ACT, 2'd0, 13'h0099, 0);
    check("R11 exit", self_ref_o, 0);
    check("R11 exit banks", bank_open_o, 4'b0000);
    drive(1, P_ACT, 2'd0, 13'h0099, 0);
    check("R11 resumed", bank_open_o, 4'b0001);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule